// File: doc/BRIEF.md
# Two-Wire Serial Slave with Write-Busy Polling

This block is a two-wire serial slave that owns a small byte store. It watches the clock and data lines by oversampling them with the system clock. It picks out START and STOP conditions and decodes the first byte after each START. That byte carries a fixed 4-bit device type (`1010`) in its upper nibble, three address bits that must equal the strapped `dev_pins_i`, and a direction bit in bit 0, where 1 means read and 0 means write. A byte write sends that byte, then an address byte, then a data byte. The slave acknowledges each of the three by pulling the data line low during the ninth clock. The write is committed only when the STOP arrives.

The store covers locations 80h through 10Fh. Address bytes 80h through FEh select the location with the same number. Address byte FFh selects location 100h, so location FFh and locations 101h through 10Fh cannot be reached. Locations 80h through 8Fh are volatile and the rest are nonvolatile. Bit 0 of location 8Fh is a write-enable latch: a write to 8Fh is always accepted, and a write to any other location is accepted only while that bit is 1.

A committed write to a nonvolatile location starts an internal write cycle lasting `WR_CYCLES` system clocks. For that whole cycle the slave stays off the bus and does not acknowledge its own address byte. A master learns that the cycle has finished by repeating the address byte until it sees an acknowledge. `busy_o` shows the cycle, and `peek_loc_i`/`peek_data_o` give a combinational view of the store.

Top module: `twi_poll_slave`

## Requirements
- R1: After reset, `busy_o` and `sda_pull_o` are 0, and every location reads 00h through the peek port.
- R2: The slave acknowledges an address byte only when bits 7:4 equal 1010 and bits 3:1 equal `dev_pins_i` (bit 3 = pin 2). On a mismatch it returns no acknowledge and the rest of the transfer changes nothing.
- R3: A byte write with direction bit 0 gets an acknowledge for the address byte, the location byte and the data byte. When the STOP arrives, the data byte is stored at the selected location.
- R4: Bit 0 of location 8Fh is the write-enable latch. A write to 8Fh always takes effect. A write to any other location while that bit is 0 leaves the store unchanged.
- R5: Address bytes 80h through FEh write the location with the same number, and address byte FFh writes location 100h.
- R6: Locations FFh and 101h through 10Fh are never modified. Address bytes below 80h are acknowledged but modify nothing and start no busy cycle.
- R7: A committed write to location 90h or above holds `busy_o` high for exactly `WR_CYCLES` clocks, starting at the STOP. A write to 80h through 8Fh raises no busy cycle.
- R8: While `busy_o` is high, the slave does not acknowledge its address byte and no write takes effect.
- R9: Once the busy cycle has ended, the address byte is acknowledged with either direction bit, so repeated polling ends with an acknowledge.
- R10: A repeated START or a STOP that arrives before the data byte has been acknowledged aborts the write: nothing is stored and no busy cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as resolved on the wire |
| dev_pins_i | input | 3 | Strapped device address bits |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| busy_o | output | 1 | Internal write cycle in progress |
| peek_loc_i | input | 9 | Location to observe (80h..10Fh) |
| peek_data_o | output | 8 | Content of the observed location, 00h outside the range |

## Verification
The hardest behaviour to reach is the withheld acknowledge, because it appears only while the internal write timer is running. To get there, the bench issues a nonvolatile write and starts the next transfer right after its STOP. The busy window is set long enough to cover several complete address bytes, so the bench can show that a write is refused during the window and that polling keeps getting no acknowledge until the window closes. The bench then measures the length of the busy pulse in clocks and confirms that polling switches to an acknowledge with either direction bit.

// File: rtl/twi_poll_pkg.sv
package twi_poll_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_DATA,
    ST_ACK_DATA,
    ST_DONE,
    ST_SKIP
  } eng_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_sh[i] <= scl_sh[i-1];
        sda_sh[i] <= sda_sh[i-1];
      end
      scl_d <= scl_sh[SYNC_STAGES-1];
      sda_d <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sh[SYNC_STAGES-1];
  assign sda_o      = sda_sh[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edges while clock stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  p_start_stop_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_poll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] dev_pins_i,
  input  logic       busy_i,
  output logic       ack_drive_o,
  output logic       wr_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  eng_state_e state_q;
  logic [7:0] sh_q, addr_q, data_q;
  logic [3:0] cnt_q;
  logic       ack_q, rw_q;
  logic       id_ok;

  assign id_ok = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == dev_pins_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_DATA: begin
          if (scl_rise_i && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (state_q == ST_DEV) begin
              if (id_ok) begin
                ack_q   <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_ACK_DEV;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_ADDR) begin
              addr_q  <= sh_q;
              ack_q   <= 1'b1;
              state_q <= ST_ACK_ADDR;
            end else begin
              data_q  <= sh_q;
              ack_q   <= 1'b1;
              state_q <= ST_ACK_DATA;
            end
          end
        end
        ST_ACK_DEV, ST_ACK_ADDR, ST_ACK_DATA: begin
          if (scl_fall_i) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            case (state_q)
              ST_ACK_DEV:  state_q <= rw_q ? ST_SKIP : ST_ADDR;
              ST_ACK_ADDR: state_q <= ST_DATA;
              default:     state_q <= ST_DONE;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  assign ack_drive_o = ack_q;
  assign wr_o        = stop_i && (state_q == ST_DONE);
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = data_q;

  // acknowledge only begins while the clock is low
  p_ack_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> !scl_i);
  // no address acknowledge when the busy cycle was running at decision time
  p_no_ack_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_q) && state_q == ST_ACK_DEV) |-> !$past(busy_i));
  p_no_commit_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !busy_i);
  p_commit_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> (state_q == ST_IDLE) && !ack_q);
endmodule

// File: rtl/twi_store.sv
module twi_store #(
  parameter logic [8:0] BASE_LOC  = 9'h080,
  parameter logic [8:0] REMAP_LOC = 9'h100,
  parameter logic [8:0] WEL_LOC   = 9'h08F,
  parameter int         LOC_COUNT = 144,
  parameter int         VOL_COUNT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [8:0] peek_loc_i,
  output logic [7:0] peek_data_o,
  output logic       nv_start_o
);
  localparam int IDX_W = $clog2(LOC_COUNT);
  localparam logic [8:0] WEL_OFF = WEL_LOC - BASE_LOC;
  localparam logic [8:0] FF_OFF  = 9'h0FF - BASE_LOC;
  localparam logic [8:0] LOC_CNT9 = 9'(LOC_COUNT);
  localparam logic [8:0] VOL_CNT9 = 9'(VOL_COUNT);

  logic [7:0] mem_q [LOC_COUNT];
  logic [8:0] loc, off, poff;
  logic       in_range, wel, is_wel, write_ok;

  assign loc      = (wr_addr_i == 8'hFF) ? REMAP_LOC : {1'b0, wr_addr_i};
  assign off      = loc - BASE_LOC;
  assign in_range = (loc >= BASE_LOC) && (off < LOC_CNT9);
  assign wel      = mem_q[WEL_OFF[IDX_W-1:0]][0];
  assign is_wel   = (off == WEL_OFF);
  assign write_ok = wr_en_i && in_range && (is_wel || wel);
  assign nv_start_o = write_ok && (off >= VOL_CNT9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LOC_COUNT; i++) mem_q[i] <= '0;
    end else if (write_ok) begin
      mem_q[off[IDX_W-1:0]] <= wr_data_i;
    end
  end

  assign poff = peek_loc_i - BASE_LOC;
  assign peek_data_o = (peek_loc_i >= BASE_LOC && poff < LOC_CNT9) ?
                       mem_q[poff[IDX_W-1:0]] : 8'h00;

  p_nv_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> wel);
  p_ff_loc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mem_q[FF_OFF[IDX_W-1:0]]));
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int CYCLES = 1_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_busy_from_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_busy_full_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == CW'(1));
endmodule

// File: rtl/twi_poll_slave.sv
module twi_poll_slave #(
  parameter int         WR_CYCLES   = 1_250_000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [8:0] BASE_LOC    = 9'h080,
  parameter logic [8:0] REMAP_LOC   = 9'h100,
  parameter logic [8:0] WEL_LOC     = 9'h08F,
  parameter int         LOC_COUNT   = 144,
  parameter int         VOL_COUNT   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  output logic       sda_pull_o,
  output logic       busy_o,
  input  logic [8:0] peek_loc_i,
  output logic [7:0] peek_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic wr, nv_start;
  logic [7:0] wr_addr, wr_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_byte_engine u_eng (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .dev_pins_i, .busy_i(busy_o),
    .ack_drive_o(sda_pull_o),
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  twi_store #(
    .BASE_LOC(BASE_LOC), .REMAP_LOC(REMAP_LOC), .WEL_LOC(WEL_LOC),
    .LOC_COUNT(LOC_COUNT), .VOL_COUNT(VOL_COUNT)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .peek_loc_i, .peek_data_o, .nv_start_o(nv_start)
  );

  twi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(nv_start), .busy_o
  );

  p_quiet_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(sda_pull_o)) |-> !sda_pull_o);
endmodule

// File: tb/twi_poll_slave_test.sv
module twi_poll_slave_test;
  localparam int WR_CYC = 1500;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [8:0] peek = 9'h080;
  logic       sda_pull, busy;
  logic [7:0] pdata;
  wire        sda_line = sda_m & ~sda_pull;

  twi_poll_slave #(.WR_CYCLES(WR_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_pins_i(pins), .sda_pull_o(sda_pull), .busy_o(busy),
    .peek_loc_i(peek), .peek_data_o(pdata)
  );

  int n_tests = 0, n_fail = 0;
  int run_len = 0, last_run = 0;

  always @(negedge clk) begin
    if (busy) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_run <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  function automatic logic [7:0] dev(logic [3:0] typ, logic [2:0] p, logic rw);
    return {typ, p, rw};
  endfunction

  task automatic peek_at(input logic [8:0] l, output logic [7:0] d);
    peek = l; wq(1); d = pdata;
  endtask

  task automatic write_txn(input logic [7:0] db, input logic [7:0] a, input logic [7:0] d,
                           output bit a0, output bit a1, output bit a2);
    bus_start();
    send_byte(db, a0);
    send_byte(a, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin wq(1); g++; end
    wq(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 busy after reset", busy, 0);
    chk("R1 sda_pull after reset", sda_pull, 0);
    peek_at(9'h090, d); chk("R1 loc 90h after reset", d, 0);
    peek_at(9'h08F, d); chk("R1 loc 8Fh after reset", d, 0);
  endtask

  task automatic t_wel();
    bit a0, a1, a2; logic [7:0] d;
    write_txn(dev(4'hA, pins, 0), 8'h85, 8'h5A, a0, a1, a2);
    chk("R3 acks", {a0, a1, a2}, 3'b111);
    peek_at(9'h085, d); chk("R4 write blocked by latch", d, 0);
    write_txn(dev(4'hA, pins, 0), 8'h8F, 8'h01, a0, a1, a2);
    peek_at(9'h08F, d); chk("R4 latch location written", d, 8'h01);
    chk("R7 volatile no busy", busy, 0);
    write_txn(dev(4'hA, pins, 0), 8'h85, 8'h5A, a0, a1, a2);
    peek_at(9'h085, d); chk("R3 volatile write stored", d, 8'h5A);
  endtask

  task automatic t_devsel();
    bit a0, a1, a2; logic [7:0] d;
    write_txn(dev(4'hA, 3'b100, 0), 8'h86, 8'h33, a0, a1, a2);
    chk("R2 pin mismatch nack", a0, 0);
    write_txn(dev(4'hB, pins, 0), 8'h86, 8'h33, a0, a1, a2);
    chk("R2 type mismatch nack", a0, 0);
    peek_at(9'h086, d); chk("R2 no write on mismatch", d, 0);
  endtask

  task automatic t_remap();
    bit a0, a1, a2; logic [7:0] d;
    write_txn(dev(4'hA, pins, 0), 8'hFF, 8'hC3, a0, a1, a2);
    chk("R7 busy after nonvolatile write", busy, 1);
    wait_idle();
    chk("R7 busy length", last_run, WR_CYC);
    peek_at(9'h100, d); chk("R5 FFh maps to 100h", d, 8'hC3);
    peek_at(9'h0FF, d); chk("R6 loc FFh untouched", d, 0);
    write_txn(dev(4'hA, pins, 0), 8'hFE, 8'h11, a0, a1, a2);
    wait_idle();
    peek_at(9'h0FE, d); chk("R5 FEh direct", d, 8'h11);
  endtask

  task automatic t_unreach();
    bit a0, a1, a2; logic [7:0] d; int bad = 0;
    write_txn(dev(4'hA, pins, 0), 8'h40, 8'h22, a0, a1, a2);
    chk("R6 low address acked", {a0, a1, a2}, 3'b111);
    chk("R6 low address no busy", busy, 0);
    for (int l = 9'h101; l <= 9'h10F; l++) begin
      peek_at(9'(l), d);
      if (d != 0) bad++;
    end
    peek_at(9'h0FF, d); if (d != 0) bad++;
    chk("R6 unreachable locations zero", bad, 0);
  endtask

  task automatic t_busy();
    bit a0, a1, a2; logic [7:0] d;
    write_txn(dev(4'hA, pins, 0), 8'h90, 8'hA5, a0, a1, a2);
    chk("R7 busy raised", busy, 1);
    write_txn(dev(4'hA, pins, 0), 8'h91, 8'h77, a0, a1, a2);
    chk("R8 nack while busy", a0, 0);
    wait_idle();
    chk("R7 busy length second", last_run, WR_CYC);
    peek_at(9'h091, d); chk("R8 write during busy dropped", d, 0);
    peek_at(9'h090, d); chk("R7 nonvolatile stored", d, 8'hA5);
  endtask

  task automatic t_poll();
    bit a0, a1, a2, ack; int polls = 0;
    write_txn(dev(4'hA, pins, 0), 8'h92, 8'h3C, a0, a1, a2);
    ack = 0;
    while (!ack && polls < 40) begin
      bus_start();
      send_byte(dev(4'hA, pins, 1), ack);
      bus_stop();
      polls++;
    end
    chk("R9 poll eventually acked", ack, 1);
    chk("R9 poll needed retries", polls > 1, 1);
    chk("R9 not busy at ack", busy, 0);
    bus_start();
    send_byte(dev(4'hA, pins, 0), ack);
    bus_stop();
    chk("R9 write-direction poll acked", ack, 1);
  endtask

  task automatic t_abort();
    bit a0, a1, a2; logic [7:0] d;
    bus_start();
    send_byte(dev(4'hA, pins, 0), a0);
    send_byte(8'h93, a1);
    bus_start();
    send_byte(dev(4'hA, pins, 0), a0);
    send_byte(8'h94, a1);
    send_byte(8'h66, a2);
    bus_stop();
    wait_idle();
    peek_at(9'h093, d); chk("R10 restart aborts first write", d, 0);
    peek_at(9'h094, d); chk("R10 write after restart", d, 8'h66);
    bus_start();
    send_byte(dev(4'hA, pins, 0), a0);
    send_byte(8'h95, a1);
    bus_stop();
    chk("R10 early stop no busy", busy, 0);
    peek_at(9'h095, d); chk("R10 early stop no write", d, 0);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_wel();
    t_devsel();
    t_remap();
    t_unreach();
    t_busy();
    t_poll();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule